// File: doc/BRIEF.md
# Descriptor Queue Manager

This block keeps a large set of hardware FIFO queues of fixed-size descriptors. Every descriptor sits in one configured memory region and is identified by its index within that region. A queue is a linked list threaded through an internal link RAM that has one entry per descriptor index, plus a head, a tail and an occupancy count held for each queue. Software or a neighbouring DMA engine pushes a descriptor by writing its address to the queue's port register. The low five bits of that write carry a size hint, which the block ignores. A read of the same port register pops the queue's head and returns its address with the low five bits cleared. A read of an empty queue returns zero.

A bank of read-only status words shows which queues hold at least one entry, 32 queues per word. One interrupt line is high while any queue numbered at or above a configured first completion queue is non-empty. A push whose address does not map to a valid descriptor is dropped and sets a sticky error flag. All access is through a 32-bit register port with separate write and read address buses. Read data is registered.

Top module: `desc_queue_mgr`

## Requirements
- R1: Each queue is strict FIFO. A pop returns the oldest pushed descriptor address. A pop of an empty queue returns 0 and changes nothing.
- R2: A popped address always has bits 4:0 equal to 0, whatever size hint was written in bits 4:0 of the push.
- R3: Status word w is read at byte address 0x90 + 4*w. Bit b of that word is 1 exactly when queue 32*w + b holds at least one descriptor.
- R4: `irq` is 1 while any queue numbered FIRST_COMP or higher is non-empty. It returns to 0 once all of those queues are drained. Queues below FIRST_COMP never raise it.
- R5: A push is dropped, and the error flag is set, in each of these cases: the address is below the region base; the offset exceeds the region's descriptor count (32 << ctrl[3:0]); the resulting index is at or above the link size register or DESC_NUM. The error flag is read as bit 0 at address 0x8C. Any write to 0x8C clears it.
- R6: The descriptor size is 32 << ctrl[11:8] bytes. A push whose offset from the base (taken with bits 4:0 cleared) is not a multiple of the descriptor size is dropped, and the error flag is set.
- R7: If a push and a pop target the same queue in one cycle, the pop is done first. On an empty queue the read returns 0 and the pushed descriptor remains queued.
- R8: The descriptor index is ctrl[31:16] + offset / size. A pop returns base + (index - ctrl[31:16]) * size, so a valid push address comes back unchanged apart from bits 4:0. Base (0x1000), region control (0x1004) and link size (0x84) are readable registers.
- R9: The port register of queue n is at 0x2000 + 0x10*n + 0xC. Read data appears on `rd_data` in the cycle after `rd_en`, and holds until the next read.
- R10: After reset every queue is empty, `irq` is 0, `rd_data` is 0, and the configuration registers and error flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (pops when it addresses a queue port) |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Completion interrupt |

## Verification
The bench attacks a push and a pop to the same queue in one cycle, for an empty queue, a queue holding one entry and a queue holding two. A design that pops after pushing would return the new descriptor or lose the head link. Rejected pushes are driven in every form: below the base, an index past the link size, a misaligned offset with 64-byte descriptors, and an index pushed over the limit by the start index. A design that checked too little would corrupt a queue, and the following empty pop would return non-zero. Sweeps across all queues check every status bit against a bench model, including the bits in the second word. They also check that `irq` ignores queues below the first completion number and drops only when the last completion queue empties.

// File: rtl/dqm_pkg.sv
`timescale 1ns/1ps
package dqm_pkg;
  typedef enum logic [2:0] {
    RK_NONE, RK_LSIZE, RK_ERR, RK_STAT, RK_BASE, RK_CTRL, RK_QPORT
  } reg_kind_e;
  localparam logic [15:0] A_LSIZE   = 16'h0084;
  localparam logic [15:0] A_ERR     = 16'h008C;
  localparam logic [5:0]  STAT_WORD = 6'h24;   // 0x90 >> 2
  localparam logic [15:0] A_BASE    = 16'h1000;
  localparam logic [15:0] A_CTRL    = 16'h1004;
endpackage

// File: rtl/dqm_addr_dec.sv
`timescale 1ns/1ps
module dqm_addr_dec
  import dqm_pkg::*;
#(
  parameter int unsigned NUM_Q  = 160,
  parameter int unsigned NWORDS = 5,
  localparam int unsigned QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned WW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [15:0]   addr,
  output reg_kind_e     kind,
  output logic [QW-1:0] qnum,
  output logic [WW-1:0] word
);
  logic [31:0] wofs;
  always_comb begin
    kind = RK_NONE;
    qnum = '0;
    word = '0;
    wofs = 32'(addr[7:2]) - 32'(STAT_WORD);
    if (addr == A_LSIZE)      kind = RK_LSIZE;
    else if (addr == A_ERR)   kind = RK_ERR;
    else if (addr == A_BASE)  kind = RK_BASE;
    else if (addr == A_CTRL)  kind = RK_CTRL;
    else if (addr[15:8] == 8'h00 && addr[1:0] == 2'b00 &&
             addr[7:2] >= STAT_WORD && wofs < NWORDS) begin
      kind = RK_STAT;
      word = WW'(wofs);
    end else if (addr[15:12] == 4'h2 && addr[3:0] == 4'hC &&
                 32'(addr[11:4]) < NUM_Q) begin
      kind = RK_QPORT;
      qnum = QW'(addr[11:4]);
    end
  end
endmodule

// File: rtl/dqm_xlate.sv
`timescale 1ns/1ps
module dqm_xlate #(
  parameter int unsigned DESC_NUM = 128,
  localparam int unsigned IW = $clog2(DESC_NUM)
) (
  input  logic [31:0]   base,
  input  logic [31:0]   ctrl,
  input  logic [31:0]   lsize,
  input  logic [31:0]   push_addr,
  input  logic [IW-1:0] pop_idx,
  output logic [IW-1:0] push_idx,
  output logic          push_ok,
  output logic [31:0]   pop_addr
);
  logic [4:0]  szl, cnl;
  logic [31:0] aligned, ofs, rel, idx32, szmask, start;
  always_comb begin
    szl     = 5'd5 + {1'b0, ctrl[11:8]};
    cnl     = 5'd5 + {1'b0, ctrl[3:0]};
    start   = {16'b0, ctrl[31:16]};
    aligned = {push_addr[31:5], 5'b0};
    ofs     = aligned - base;
    rel     = ofs >> szl;
    idx32   = start + rel;
    szmask  = (32'd1 << szl) - 32'd1;
    push_ok = (aligned >= base) && ((ofs & szmask) == 32'd0) &&
              (rel < (32'd1 << cnl)) && (idx32 < lsize) &&
              (idx32 < 32'(DESC_NUM));
    push_idx = IW'(idx32);
    pop_addr = base + ((32'(pop_idx) - start) << szl);
  end
endmodule

// File: rtl/dqm_qstore.sv
`timescale 1ns/1ps
module dqm_qstore #(
  parameter int unsigned NUM_Q    = 160,
  parameter int unsigned DESC_NUM = 128,
  localparam int unsigned QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned IW = $clog2(DESC_NUM),
  localparam int unsigned CW = $clog2(DESC_NUM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [QW-1:0]    push_q,
  input  logic [IW-1:0]    push_idx,
  input  logic             pop_en,
  input  logic [QW-1:0]    pop_q,
  output logic [IW-1:0]    head_idx,
  output logic             pop_hit,
  output logic [NUM_Q-1:0] qnz
);
  logic [IW-1:0] head [NUM_Q];
  logic [IW-1:0] tail [NUM_Q];
  logic [CW-1:0] cnt  [NUM_Q];
  logic [IW-1:0] link [DESC_NUM];

  logic          same_q, push_empty;
  logic [CW-1:0] push_base, pop_cnt_nxt, push_cnt_nxt;
  logic [IW-1:0] pop_head_nxt;

  // next-state
  always_comb begin
    pop_hit      = pop_en && (cnt[pop_q] != '0);
    head_idx     = head[pop_q];
    pop_head_nxt = link[head[pop_q]];
    pop_cnt_nxt  = cnt[pop_q] - CW'(1);
    same_q       = push_en && pop_hit && (push_q == pop_q);
    push_base    = same_q ? (cnt[push_q] - CW'(1)) : cnt[push_q];
    push_empty   = (push_base == '0);
    push_cnt_nxt = push_base + CW'(1);
  end

  // per-queue registers; the push updates come last so they win on a shared queue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NUM_Q; q++) begin
        head[q] <= '0;
        tail[q] <= '0;
        cnt[q]  <= '0;
      end
    end else begin
      if (pop_hit) begin
        head[pop_q] <= pop_head_nxt;
        cnt[pop_q]  <= pop_cnt_nxt;
      end
      if (push_en) begin
        tail[push_q] <= push_idx;
        cnt[push_q]  <= push_cnt_nxt;
        if (push_empty) head[push_q] <= push_idx;
      end
    end
  end

  // link RAM, no reset
  always_ff @(posedge clk) begin
    if (push_en && !push_empty) link[tail[push_q]] <= push_idx;
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_nz
    assign qnz[g] = (cnt[g] != '0);
  end
endmodule

// File: rtl/desc_queue_mgr.sv
`timescale 1ns/1ps
module desc_queue_mgr
  import dqm_pkg::*;
#(
  parameter int unsigned NUM_Q      = 160,
  parameter int unsigned DESC_NUM   = 128,
  parameter int unsigned FIRST_COMP = 93
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [15:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int unsigned NWORDS = (NUM_Q + 31) / 32;
  localparam int unsigned QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int unsigned WW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned IW = $clog2(DESC_NUM);
  localparam logic [NUM_Q-1:0] COMP_MASK = {NUM_Q{1'b1}} << FIRST_COMP;

  reg_kind_e       wkind, rkind;
  logic [QW-1:0]   wq, rq;
  logic [WW-1:0]   wword_unused, rword;
  logic [31:0]     base_q, ctrl_q, lsize_q, rd_data_q;
  logic [31:0]     base_d, ctrl_d, lsize_d, rd_mux, pop_addr;
  logic            err_q, err_d;
  logic [IW-1:0]   push_idx, head_idx;
  logic            push_ok, push_en, push_bad, pop_en, pop_hit;
  logic [NUM_Q-1:0] qnz;
  logic [NWORDS*32-1:0] stat_vec;

  dqm_addr_dec #(.NUM_Q(NUM_Q), .NWORDS(NWORDS)) u_wdec (
    .addr(wr_addr), .kind(wkind), .qnum(wq), .word(wword_unused));
  dqm_addr_dec #(.NUM_Q(NUM_Q), .NWORDS(NWORDS)) u_rdec (
    .addr(rd_addr), .kind(rkind), .qnum(rq), .word(rword));

  dqm_xlate #(.DESC_NUM(DESC_NUM)) u_xlate (
    .base(base_q), .ctrl(ctrl_q), .lsize(lsize_q), .push_addr(wr_data),
    .pop_idx(head_idx), .push_idx(push_idx), .push_ok(push_ok),
    .pop_addr(pop_addr));

  assign push_en  = wr_en && (wkind == RK_QPORT) && push_ok;
  assign push_bad = wr_en && (wkind == RK_QPORT) && !push_ok;
  assign pop_en   = rd_en && (rkind == RK_QPORT);

  dqm_qstore #(.NUM_Q(NUM_Q), .DESC_NUM(DESC_NUM)) u_store (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_q(wq),
    .push_idx(push_idx), .pop_en(pop_en), .pop_q(rq),
    .head_idx(head_idx), .pop_hit(pop_hit), .qnz(qnz));

  // next-state
  always_comb begin
    stat_vec = '0;
    stat_vec[NUM_Q-1:0] = qnz;
    base_d  = (wr_en && wkind == RK_BASE)  ? wr_data : base_q;
    ctrl_d  = (wr_en && wkind == RK_CTRL)  ? wr_data : ctrl_q;
    lsize_d = (wr_en && wkind == RK_LSIZE) ? wr_data : lsize_q;
    if (push_bad)                        err_d = 1'b1;
    else if (wr_en && wkind == RK_ERR)   err_d = 1'b0;
    else                                 err_d = err_q;
    unique case (rkind)
      RK_LSIZE: rd_mux = lsize_q;
      RK_ERR:   rd_mux = {31'b0, err_q};
      RK_STAT:  rd_mux = stat_vec[32*rword +: 32];
      RK_BASE:  rd_mux = base_q;
      RK_CTRL:  rd_mux = ctrl_q;
      RK_QPORT: rd_mux = pop_hit ? {pop_addr[31:5], 5'b0} : 32'd0;
      default:  rd_mux = 32'd0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      ctrl_q    <= '0;
      lsize_q   <= '0;
      err_q     <= 1'b0;
      rd_data_q <= '0;
    end else begin
      base_q  <= base_d;
      ctrl_q  <= ctrl_d;
      lsize_q <= lsize_d;
      err_q   <= err_d;
      if (rd_en) rd_data_q <= rd_mux;
    end
  end

  assign rd_data = rd_data_q;
  assign irq     = |(qnz & COMP_MASK);
endmodule

// File: rtl/dqm_checker.sv
`timescale 1ns/1ps
module dqm_checker #(
  parameter int unsigned NUM_Q = 160
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [15:0]      rd_addr,
  input logic             wr_en,
  input logic [15:0]      wr_addr,
  input logic [31:0]      rd_data,
  input logic             irq,
  input logic [NUM_Q-1:0] qnz,
  input logic             err_q,
  input logic             push_bad
);
  logic [255:0] qpad;
  logic         is_port;
  always_comb begin
    qpad = '0;
    qpad[NUM_Q-1:0] = qnz;
    is_port = (rd_addr[15:12] == 4'h2) && (rd_addr[3:0] == 4'hC);
  end

  // R2
  pop_lowbits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && is_port |=> rd_data[4:0] == 5'd0);

  // R1
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && is_port && (32'(rd_addr[11:4]) < NUM_Q) && !qpad[rd_addr[11:4]]
    |=> rd_data == 32'd0);

  // R5
  bad_push_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_bad |=> err_q);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(wr_en && wr_addr == 16'h008C) |=> err_q);

  // R4
  irq_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (qnz != '0));
endmodule

bind desc_queue_mgr dqm_checker #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_data(rd_data), .irq(irq),
  .qnz(qnz), .err_q(err_q), .push_bad(push_bad));

// File: tb/tb_desc_queue_mgr.sv
`timescale 1ns/1ps
module tb_desc_queue_mgr;
  localparam int NQ = 40;
  localparam int ND = 16;
  localparam int FC = 36;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [15:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic irq;
  int tests = 0, fails = 0;

  logic [31:0] mq [NQ][ND];
  int          mcnt [NQ];

  always #10 clk = ~clk;

  desc_queue_mgr #(.NUM_Q(NQ), .DESC_NUM(ND), .FIRST_COMP(FC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  function automatic logic [15:0] qport(int q);
    return 16'(16'h2000 + q * 16 + 12);
  endfunction
  function automatic logic [31:0] daddr(int i);
    return BASE + 32'(i * 32);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask
  task automatic both(input logic [15:0] wa, input logic [31:0] wd,
                      input logic [15:0] ra, output logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = wa; wr_data = wd;
    rd_en = 1'b1; rd_addr = ra;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; d = rd_data;
  endtask

  task automatic mpush(input int q, input logic [31:0] a);
    mq[q][mcnt[q]] = {a[31:5], 5'b0};
    mcnt[q]++;
  endtask
  task automatic mpop(input int q, output logic [31:0] a);
    if (mcnt[q] == 0) a = 32'd0;
    else begin
      a = mq[q][0];
      for (int k = 1; k < ND; k++) mq[q][k-1] = mq[q][k];
      mcnt[q]--;
    end
  endtask
  function automatic logic [31:0] mstat(int w);
    logic [31:0] s = 32'd0;
    for (int b = 0; b < 32; b++)
      if (32 * w + b < NQ) s[b] = (mcnt[32 * w + b] != 0);
    return s;
  endfunction
  function automatic logic mirq();
    logic r = 1'b0;
    for (int q = FC; q < NQ; q++) if (mcnt[q] != 0) r = 1'b1;
    return r;
  endfunction

  task automatic push_m(input int q, input int i, input string tag);
    wr(qport(q), daddr(i) | 32'd2);
    mpush(q, daddr(i));
    chk(tag, {31'b0, irq}, {31'b0, mirq()});
  endtask
  task automatic pop_m(input int q, input string tag);
    logic [31:0] got, exp;
    rd(qport(q), got);
    mpop(q, exp);
    chk(tag, got, exp);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, mirq()});
  endtask
  task automatic err_is(input logic e, input string tag);
    logic [31:0] got;
    rd(16'h008C, got);
    chk(tag, got, {31'b0, e});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int q = 0; q < NQ; q++) mcnt[q] = 0;
    wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 rd_data", rd_data, 32'd0);
    chk("R10 irq", {31'b0, irq}, 32'd0);
    rd(16'h0090, v); chk("R10 status0", v, 32'd0);
    rd(16'h1000, v); chk("R10 base", v, 32'd0);
    rd(qport(3), v); chk("R10 empty pop", v, 32'd0);
    err_is(1'b0, "R10 err");

    // R8 configuration registers
    wr(16'h1000, BASE); wr(16'h1004, 32'd0); wr(16'h0084, 32'(ND));
    rd(16'h1000, v); chk("R8 base readback", v, BASE);
    rd(16'h0084, v); chk("R8 lsize readback", v, 32'(ND));

    // R1 R2 R3 R9 FIFO order on one queue
    push_m(5, 3, "R1 push"); push_m(5, 7, "R1 push"); push_m(5, 1, "R1 push");
    rd(16'h0090, v); chk("R3 status q5", v, 32'h20);
    pop_m(5, "R1 R2 R9 pop"); pop_m(5, "R1 pop"); pop_m(5, "R1 pop");
    pop_m(5, "R1 empty pop");
    rd(16'h0090, v); chk("R3 status drained", v, 32'd0);

    // R4 interrupt window
    push_m(35, 2, "R4 below first completion");
    push_m(36, 4, "R4 first completion queue");
    pop_m(36, "R4 drain completion");
    pop_m(35, "R4 drain other");

    // R3 second word
    push_m(33, 6, "R3 push");
    rd(16'h0094, v); chk("R3 word1", v, 32'h2);
    rd(16'h0090, v); chk("R3 word0", v, 32'h0);
    pop_m(33, "R3 pop");

    // R5 out-of-range pushes
    wr(qport(0), BASE - 32'd32);
    err_is(1'b1, "R5 below base err");
    pop_m(0, "R5 below base ignored");
    wr(16'h008C, 32'd0); err_is(1'b0, "R5 err cleared");
    wr(qport(0), daddr(ND));
    err_is(1'b1, "R5 over link size err");
    pop_m(0, "R5 over link size ignored");
    wr(16'h008C, 32'd0);

    // R6 misaligned with 64-byte descriptors
    wr(16'h1004, 32'h0000_0100);
    wr(qport(1), BASE + 32'd32);
    err_is(1'b1, "R6 misaligned err");
    pop_m(1, "R6 misaligned ignored");
    wr(16'h008C, 32'd0);
    wr(qport(1), BASE + 32'd64); mpush(1, BASE + 32'd64);
    err_is(1'b0, "R6 aligned accepted");
    pop_m(1, "R6 aligned pop");
    wr(16'h1004, 32'd0);

    // R8 start index shifts the valid range
    wr(16'h1004, 32'h0004_0000);
    wr(qport(2), daddr(11) | 32'd2); mpush(2, daddr(11));
    pop_m(2, "R8 start index round trip");
    wr(qport(2), daddr(12));
    err_is(1'b1, "R8 start index over limit");
    pop_m(2, "R8 over limit ignored");
    wr(16'h008C, 32'd0);
    wr(16'h1004, 32'd0);

    // R7 push and pop on the same queue in one cycle
    both(qport(9), daddr(5), qport(9), v);
    chk("R7 empty pop-first", v, 32'd0); mpush(9, daddr(5));
    pop_m(9, "R7 pushed kept");
    push_m(9, 6, "R7 setup");
    both(qport(9), daddr(7), qport(9), v);
    chk("R7 one entry", v, daddr(6)); mpush(9, daddr(7)); mcnt[9] = 1; mq[9][0] = daddr(7);
    pop_m(9, "R7 one entry follow");
    pop_m(9, "R7 one entry empty");
    push_m(9, 8, "R7 setup"); push_m(9, 9, "R7 setup");
    both(qport(9), daddr(10), qport(9), v);
    chk("R7 two entries", v, daddr(8));
    mcnt[9] = 2; mq[9][0] = daddr(9); mq[9][1] = daddr(10);
    pop_m(9, "R7 two entries follow"); pop_m(9, "R7 two entries last");
    pop_m(9, "R7 two entries empty");

    // R1 R3 R4 sweeps over all queues and descriptors
    for (int pat = 0; pat < 2; pat++) begin
      for (int i = 0; i < ND; i++) begin
        int q;
        q = (pat == 0) ? (i % 4) * 11 : (NQ - 1 - (i % 3));
        push_m(q, i, "R1 R4 sweep push");
        for (int w = 0; w < 2; w++) begin
          rd(16'(16'h0090 + 4 * w), v);
          chk("R3 sweep status", v, mstat(w));
        end
      end
      for (int q = 0; q < NQ; q++) begin
        while (mcnt[q] != 0) pop_m(q, "R1 sweep pop");
        pop_m(q, "R1 sweep empty");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule